// File: doc/BRIEF.md
# Banked Peripheral Clock Gate Register Block

This block holds one clock-enable bit for each of 64 peripherals and lets software switch those bits through a small register-bus slave. The enables are split into two banks of 32. Each bank has three word registers: a write-one-to-set register that switches clocks on, a write-one-to-clear register that switches clocks off, and a status register that reads back the current enable vector. Because set and clear are separate registers, software can change one clock without a read-modify-write, and writes never disturb bits written as zero.

The two lowest peripheral indices are fixed on. Writes cannot gate them, and the status register always reports them as on. Each enable drives a clock-enable output. An optional gating cell per output turns the enable into a gated copy of the block clock. The cell latches the enable while the clock is low, so a gated clock never shows a shortened pulse.

Top module: `pgate_regs`

## Requirements
- R1: After reset, enables for indices 2 to 63 are 0, enables for indices 0 and 1 are 1, and the read data is 0.
- R2: Indices 0 and 1 are always enabled. Set or clear writes to bits 0 and 1 of bank 0 do not change them, and a bank 0 status read returns 1 in bits 0 and 1.
- R3: The word address has two fields. Bits [1:0] select the function: 0 is set, 1 is clear, 2 is status and 3 is reserved. Bit 2 selects the bank: 0 covers indices 0 to 31 and 1 covers indices 32 to 63. Index i maps to bit (i mod 32) of its bank.
- R4: A write to a set register enables every index whose data bit is 1, from the clock edge that accepts the write. Indices whose data bit is 0 keep their state.
- R5: A write to a clear register disables every gateable index whose data bit is 1, from the clock edge that accepts the write. Indices whose data bit is 0 keep their state.
- R6: A status read returns the bank's current enable vector. Read data is registered: it updates on the edge that samples the read strobe and holds until the next read.
- R7: Reads of the set, clear and reserved addresses return 0.
- R8: Writes to the status and reserved addresses change no enable.
- R9: When gating cells are present, each gated clock output is low while the block clock is low. During a high phase it equals the clock ANDed with the enable value held during the preceding low phase. A new enable therefore first appears in the high phase after the one that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the clock that the gating cells gate |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Word address: bank in bit 2, function in bits [1:0] |
| wrData | input | 32 | Write data, one bit per index of the addressed bank |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| rdEn | input | 1 | Read strobe, sampled on the rising clock edge |
| rdData | output | 32 | Registered read data |
| clkEn | output | 64 | Clock-enable level per peripheral index |
| gatedClk | output | 64 | Gated clock per peripheral index |

## Verification
Wrong enable state shows on the clkEn port on the edge that accepts the faulty write, and on rdData one cycle after a status read of that bank. The bench compares all 64 enables after every bus operation, so a lost set, a stray clear or a wrong bank decode shows up within one operation. A gating cell that latches at the wrong phase shows up as a gated clock that is high during a low phase, or that takes a new enable one high phase early.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int BANK_W     = 32;
  localparam int NUM_BANKS  = 2;
  localparam int ALWAYS_ON  = 2;
  localparam int NUM_PERIPH = BANK_W * NUM_BANKS;
  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W     = BANK_SEL_W + 2;

  typedef enum logic [1:0] {
    FN_SET  = 2'd0,
    FN_CLR  = 2'd1,
    FN_STAT = 2'd2,
    FN_RSVD = 2'd3
  } regFn_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  setStb;
    logic [NUM_BANKS-1:0]  clrStb;
    logic                  rdStat;
    logic                  rdZero;
    logic [BANK_SEL_W-1:0] rdBank;
  } gateStb_t;
endpackage

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output gateStb_t          stb
);
  regFn_e                fnSel;
  logic [BANK_SEL_W-1:0] bankSel;

  assign fnSel   = regFn_e'(addr[1:0]);
  assign bankSel = addr[ADDR_W-1:2];

  always_comb begin
    stb = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      stb.setStb[b] = wrEn && (fnSel == FN_SET) && (bankSel == BANK_SEL_W'(b));
      stb.clrStb[b] = wrEn && (fnSel == FN_CLR) && (bankSel == BANK_SEL_W'(b));
    end
    stb.rdStat = rdEn && (fnSel == FN_STAT);
    stb.rdZero = rdEn && (fnSel != FN_STAT);
    stb.rdBank = bankSel;
  end

  AST_ONE_WR_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setStb, stb.clrStb})); // R3

  AST_STB_NEEDS_WR: assert property (@(posedge clk) disable iff (!rstN)
    (|{stb.setStb, stb.clrStb}) |-> (wrEn && addr[1] == 1'b0)); // R8
endmodule

// File: rtl/pgate_datapath.sv
module pgate_datapath
  import pgate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  gateStb_t              stb,
  input  logic [BANK_W-1:0]     wrData,
  output logic [NUM_PERIPH-1:0] clkEn,
  output logic [BANK_W-1:0]     rdData
);
  localparam logic [NUM_PERIPH-1:0] FIXED_ON =
    {{(NUM_PERIPH-ALWAYS_ON){1'b0}}, {ALWAYS_ON{1'b1}}};
  localparam logic [NUM_PERIPH-1:0] GATE_MASK = ~FIXED_ON;

  logic [NUM_PERIPH-1:0] setMask, clrMask, stateQ, stateD;
  logic [BANK_W-1:0]     bankView [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign setMask[b*BANK_W +: BANK_W] = stb.setStb[b] ? wrData : '0;
    assign clrMask[b*BANK_W +: BANK_W] = stb.clrStb[b] ? wrData : '0;
    assign bankView[b] = stateQ[b*BANK_W +: BANK_W];
  end

  // Clear has priority over set for any bit named by both.
  assign stateD = (((stateQ | setMask) & ~clrMask) & GATE_MASK) | FIXED_ON;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= FIXED_ON;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdStat) rdData <= bankView[stb.rdBank];
    else if (stb.rdZero) rdData <= '0;
  end

  assign clkEn = stateQ;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stateQ & $past(setMask & ~clrMask)) == $past(setMask & ~clrMask))); // R4

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stateQ & $past(clrMask) & GATE_MASK) == '0)); // R5

  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stateQ & ~$past(setMask | clrMask)) ==
              ($past(stateQ) & ~$past(setMask | clrMask)))); // R8

  AST_FIXED_ON: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ & FIXED_ON) == FIXED_ON); // R2
endmodule

// File: rtl/pgate_cell.sv
module pgate_cell (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic enLat;

  // Transparent while the clock is low, so the enable is stable for the whole high phase.
  always_latch begin
    if (!clk) enLat = en;
  end

  assign gclk = clk & enLat;
endmodule

// File: rtl/pgate_regs.sv
module pgate_regs
  import pgate_pkg::*;
#(
  parameter bit GATE_CELLS = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BANK_W-1:0]     wrData,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output logic [BANK_W-1:0]     rdData,
  output logic [NUM_PERIPH-1:0] clkEn,
  output logic [NUM_PERIPH-1:0] gatedClk
);
  gateStb_t stb;

  pgate_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  pgate_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .clkEn  (clkEn),
    .rdData (rdData)
  );

  if (GATE_CELLS) begin : g_cells
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_out
      if (i < ALWAYS_ON) begin : g_fixed
        assign gatedClk[i] = clk;
      end else begin : g_gate
        pgate_cell u_cell (
          .clk  (clk),
          .en   (clkEn[i]),
          .gclk (gatedClk[i])
        );
      end
    end
  end else begin : g_plain
    assign gatedClk = {NUM_PERIPH{clk}} & clkEn;
  end

  AST_RD_WO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[1:0] != FN_STAT) |=> (rdData == '0)); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R6
endmodule

// File: tb/tb_pgate_regs.sv
module tb_pgate_regs;
  import pgate_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [ADDR_W-1:0]     addr;
  logic [BANK_W-1:0]     wrData;
  logic                  wrEn;
  logic                  rdEn;
  logic [BANK_W-1:0]     rdData;
  logic [NUM_PERIPH-1:0] clkEn;
  logic [NUM_PERIPH-1:0] gatedClk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [NUM_PERIPH-1:0] model;
  logic [BANK_W-1:0]     expRd;

  pgate_regs dut (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrData   (wrData),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .rdData   (rdData),
    .clkEn    (clkEn),
    .gatedClk (gatedClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NUM_PERIPH-1:0] applyWr(logic [NUM_PERIPH-1:0] s,
                                                   logic [ADDR_W-1:0] a,
                                                   logic [BANK_W-1:0] d);
    logic [NUM_PERIPH-1:0] m;
    int bk;
    bk = int'(a[ADDR_W-1:2]);
    m = '0;
    m[bk*BANK_W +: BANK_W] = d;
    if (a[1:0] == 2'd0)      s = s | m;
    else if (a[1:0] == 2'd1) s = s & ~m;
    s[1:0] = 2'b11;
    return s;
  endfunction

  function automatic logic [BANK_W-1:0] readExp(logic [NUM_PERIPH-1:0] s,
                                               logic [ADDR_W-1:0] a);
    int bk;
    bk = int'(a[ADDR_W-1:2]);
    if (a[1:0] == 2'd2) return s[bk*BANK_W +: BANK_W];
    return '0;
  endfunction

  task automatic check(string req, logic [NUM_PERIPH-1:0] act, logic [NUM_PERIPH-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus operation: drive at a falling edge, accept at the rising edge, check at the next falling edge.
  task automatic busOp(string req, logic [ADDR_W-1:0] a, logic [BANK_W-1:0] d,
                       logic we, logic re);
    @(negedge clk);
    addr = a; wrData = d; wrEn = we; rdEn = re;
    if (re) expRd = readExp(model, a);
    if (we) model = applyWr(model, a, d);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check({req, " clkEn"}, clkEn, model);
    check({req, " rdData"}, NUM_PERIPH'(rdData), NUM_PERIPH'(expRd));
    check("R9 low phase", gatedClk, '0);
    @(posedge clk); #1;
    check("R9 high phase", gatedClk, model);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    rstN = 1'b0; addr = '0; wrData = '0; wrEn = 1'b0; rdEn = 1'b0;
    model = {{(NUM_PERIPH-2){1'b0}}, 2'b11};
    expRd = '0;
    repeat (3) @(negedge clk);
    check("R1 reset clkEn", clkEn, model);
    check("R1 reset rdData", NUM_PERIPH'(rdData), '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", clkEn, model);

    busOp("R2 stat bank0", 3'd2, '0, 1'b0, 1'b1);
    busOp("R4 set all bank0", 3'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    busOp("R5 clr all bank0", 3'd1, 32'hFFFF_FFFF, 1'b1, 1'b0);
    check("R2 fixed on after clear", NUM_PERIPH'(clkEn[1:0]), NUM_PERIPH'(2'b11));
    busOp("R2 stat fixed bits", 3'd2, '0, 1'b0, 1'b1);
    busOp("R3 set bank1 ends", 3'd4, 32'h8000_0001, 1'b1, 1'b0);
    check("R3 index 63", NUM_PERIPH'(clkEn[63]), NUM_PERIPH'(1'b1));
    check("R3 index 32", NUM_PERIPH'(clkEn[32]), NUM_PERIPH'(1'b1));
    busOp("R4 set bit4", 3'd0, 32'h10, 1'b1, 1'b0);
    busOp("R4 set bit5 keeps bit4", 3'd0, 32'h20, 1'b1, 1'b0);
    busOp("R5 clr index32", 3'd5, 32'h1, 1'b1, 1'b0);
    busOp("R8 write stat0", 3'd2, 32'hFFFF_FFFF, 1'b1, 1'b0);
    busOp("R8 write stat1", 3'd6, 32'h0, 1'b1, 1'b0);
    busOp("R8 write rsvd0", 3'd3, 32'hFFFF_FFFF, 1'b1, 1'b0);
    busOp("R8 write rsvd1", 3'd7, 32'hFFFF_FFFF, 1'b1, 1'b0);
    busOp("R6 stat bank1", 3'd6, '0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R6 rdData holds", NUM_PERIPH'(rdData), NUM_PERIPH'(expRd));
    busOp("R7 read set0", 3'd0, '0, 1'b0, 1'b1);
    busOp("R7 read clr0", 3'd1, '0, 1'b0, 1'b1);
    busOp("R7 read rsvd0", 3'd3, '0, 1'b0, 1'b1);
    busOp("R7 read set1", 3'd4, '0, 1'b0, 1'b1);
    busOp("R7 read clr1", 3'd5, '0, 1'b0, 1'b1);
    busOp("R7 read rsvd1", 3'd7, '0, 1'b0, 1'b1);
    busOp("R6 stat and write same op", 3'd2, 32'h0000_0100, 1'b1, 1'b1);

    // R9: the first high phase after the write edge still carries the old enable.
    @(negedge clk);
    addr = 3'd0; wrData = 32'h0000_0400; wrEn = 1'b1;
    @(posedge clk); #1;
    check("R9 old enable first high phase", NUM_PERIPH'(gatedClk[10]), '0);
    @(negedge clk);
    wrEn = 1'b0;
    model = applyWr(model, 3'd0, 32'h0000_0400);
    check("R9 low phase gated", NUM_PERIPH'(gatedClk[10]), '0);
    @(posedge clk); #1;
    check("R9 new enable next high phase", NUM_PERIPH'(gatedClk[10]), NUM_PERIPH'(1'b1));

    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] ra;
      logic [BANK_W-1:0] rd;
      int op;
      ra = ADDR_W'($urandom % 8);
      rd = (n % 2 == 0) ? $urandom : ($urandom & $urandom & $urandom);
      op = $urandom % 3;
      busOp("R4 R5 R6 random", ra, rd, op != 1, op != 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule